// File: doc/BRIEF.md
# Sampling Converter Parallel Bus Front End

This block is the digital side of a 12-bit, 8-channel sampling converter. A falling edge on the active-low conversion-start input launches a conversion. The block raises `busy_o`, counts a fixed run of master clock cycles, and then stores the value on `sample_i` in an output register. The register also keeps the channel number that was selected when the conversion began. The analog sampling and the approximation arithmetic are outside the block: the sample value arrives on an input port.

A host reads the result, and writes the channel selection, over a shared parallel bus. The bus uses active-low chip select, read and write. In word mode all 12 data lines carry the result. In byte mode data line 8 becomes a high-byte enable, which picks the low eight result bits or a high byte. The high byte packs the top four result bits with the 3-bit channel tag. The bus is modelled as separate in, out and output-enable vectors, so the pads sit outside the block.

The channel register is a single field in register bits 10:8. Bit 11 is reserved, and the other bits of a write are discarded.

Top module: `adc_pbus_frontend`

## Requirements
- R1: A falling edge on `conv_start_ni`, seen at a clock edge while idle, sets `busy_o` high after that same edge.
- R2: `busy_o` stays high for exactly 13 clock cycles. The value of `sample_i` at the last of those edges becomes the result, and it is readable once `busy_o` is low.
- R3: `db_oe_o` is high only while both `cs_ni` and `rd_ni` are low. Otherwise `db_oe_o` is low and `db_o` is all zero.
- R4: In word mode (`word_mode_i`=1), a read drives the full 12-bit result on `db_o[11:0]`.
- R5: In byte mode (`word_mode_i`=0) with `db_i[8]`=0, a read drives result bits 7:0 on `db_o[7:0]`, and `db_o[11:8]` is zero.
- R6: In byte mode with `db_i[8]`=1, a read drives result bits 11:8 on `db_o[3:0]` and the channel tag on `db_o[6:4]`. `db_o[7]` and `db_o[11:8]` are zero.
- R7: A write occurs at the first clock edge at which `cs_ni` and `wr_ni` are both low. In word mode it loads the channel from `db_i[10:8]`. In byte mode with `db_i[8]`=1 it loads the channel from `db_i[2:0]`. A byte-mode write with `db_i[8]`=0 leaves the channel unchanged.
- R8: A byte-mode high write with any of `db_i[7:3]` set is ignored. A word-mode write with `db_i[11]` set is ignored.
- R9: `word_mode_i` is taken only at clock edges where `cs_ni` is high. Changes made while `cs_ni` is low have no effect until `cs_ni` is high again.
- R10: A conversion-start falling edge that arrives while `busy_o` is high is ignored. It neither extends the conversion nor restarts it.
- R11: The channel tag stored with a result is the channel selected at the launching edge. A channel write during the conversion does not change that tag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Master converter clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| conv_start_ni | input | 1 | Conversion start; a falling edge launches a conversion |
| sample_i | input | 12 | Sample value stored at the end of a conversion |
| word_mode_i | input | 1 | 1 selects word mode, 0 selects byte mode |
| cs_ni | input | 1 | Chip select, active low |
| rd_ni | input | 1 | Read strobe, active low |
| wr_ni | input | 1 | Write strobe, active low |
| db_i | input | 12 | Data lines in; bit 8 is the high-byte enable in byte mode |
| db_o | output | 12 | Data lines out |
| db_oe_o | output | 1 | Output enable for the data lines |
| busy_o | output | 1 | Conversion in progress |

## Verification
Every channel is converted with four spread sample values plus all-zero and all-one corners, and each result is read in all three bus views. This shows whether bits are lost, swapped between halves, or mixed up with the tag. Writes are tried with accepted, low-byte and reserved-bit patterns, and the stored tag shows which patterns took effect. Timed patterns then check the three control rules: a mode change while selected, a start edge during a conversion, and a channel write during a conversion. Each pattern separates the correct design from one that samples or restarts at the wrong time.

// File: rtl/adc_pbus_pkg.sv
`timescale 1ns/1ps
package adc_pbus_pkg;
  typedef enum logic {BUS_BYTE = 1'b0, BUS_WORD = 1'b1} bus_mode_e;
endpackage

// File: rtl/adc_conv_seq.sv
`timescale 1ns/1ps
module adc_conv_seq #(
  parameter int unsigned DATA_W      = 12,
  parameter int unsigned CHAN_W      = 3,
  parameter int unsigned CONV_CYCLES = 13
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_ni,
  input  logic [CHAN_W-1:0] chan_i,
  input  logic [DATA_W-1:0] sample_i,
  output logic              busy_o,
  output logic [DATA_W-1:0] result_o,
  output logic [CHAN_W-1:0] tag_o
);
  localparam int unsigned CNT_W = $clog2(CONV_CYCLES);

  logic              start_q, busy_q, fall, launch, last;
  logic [CNT_W-1:0]  cnt_q;
  logic [CHAN_W-1:0] chan_hold_q, tag_q;
  logic [DATA_W-1:0] result_q;

  assign fall   = start_q & ~start_ni;
  assign launch = fall & ~busy_q;
  assign last   = busy_q && (cnt_q == CNT_W'(CONV_CYCLES - 1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) start_q <= 1'b1;
    else         start_q <= start_ni;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q      <= 1'b0;
      cnt_q       <= '0;
      chan_hold_q <= '0;
      result_q    <= '0;
      tag_q       <= '0;
    end else if (launch) begin
      busy_q      <= 1'b1;
      cnt_q       <= '0;
      chan_hold_q <= chan_i;
    end else if (busy_q) begin
      if (last) begin
        busy_q   <= 1'b0;
        result_q <= sample_i;
        tag_q    <= chan_hold_q;
      end else begin
        cnt_q <= cnt_q + 1'b1;
      end
    end
  end

  assign busy_o   = busy_q;
  assign result_o = result_q;
  assign tag_o    = tag_q;

  // independent run-length counter for the busy window
  logic [CNT_W:0] chk_len_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     chk_len_q <= '0;
    else if (busy_q) chk_len_q <= chk_len_q + 1'b1;
    else             chk_len_q <= '0;
  end

  a_r1_launch_busy: assert property (@(posedge clk_i) disable iff (!rst_ni)
    launch |=> busy_q);
  a_r2_busy_length: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(busy_q) |-> chk_len_q == (CNT_W+1)'(CONV_CYCLES));
  a_r2_result_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_q && !last) |=> $stable(result_q));
  a_r10_ignore_start: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fall && busy_q && !last) |=> busy_q && $stable(chan_hold_q));
endmodule

// File: rtl/adc_bus_ctrl.sv
`timescale 1ns/1ps
module adc_bus_ctrl
  import adc_pbus_pkg::*;
#(
  parameter int unsigned DATA_W = 12,
  parameter int unsigned BYTE_W = 8,
  parameter int unsigned CHAN_W = 3
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cs_ni,
  input  logic              wr_ni,
  input  logic              mode_i,
  input  logic [DATA_W-1:0] db_i,
  output bus_mode_e         mode_o,
  output logic [CHAN_W-1:0] chan_o
);
  bus_mode_e         mode_q;
  logic              wr_q, wr_stb, hben, hi_ok, word_ok;
  logic [CHAN_W-1:0] chan_q;

  assign wr_stb  = ~cs_ni & ~wr_ni & wr_q;
  assign hben    = db_i[BYTE_W];
  assign hi_ok   = (db_i[BYTE_W-1:CHAN_W] == '0);
  assign word_ok = (db_i[DATA_W-1:BYTE_W+CHAN_W] == '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_q   <= 1'b1;
      mode_q <= BUS_WORD;
    end else begin
      wr_q <= wr_ni;
      if (cs_ni) mode_q <= bus_mode_e'(mode_i);
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) chan_q <= '0;
    else if (wr_stb) begin
      if (mode_q == BUS_WORD) begin
        if (word_ok) chan_q <= db_i[BYTE_W +: CHAN_W];
      end else if (hben && hi_ok) begin
        chan_q <= db_i[CHAN_W-1:0];
      end
    end
  end

  assign mode_o = mode_q;
  assign chan_o = chan_q;

  a_r9_mode_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cs_ni |=> $stable(mode_q));
  a_r8_reject_high: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_stb && mode_q == BUS_BYTE && hben && !hi_ok) |=> $stable(chan_q));
  a_r7_low_keep: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_stb && mode_q == BUS_BYTE && !hben) |=> $stable(chan_q));
endmodule

// File: rtl/adc_read_mux.sv
`timescale 1ns/1ps
module adc_read_mux
  import adc_pbus_pkg::*;
#(
  parameter int unsigned DATA_W = 12,
  parameter int unsigned BYTE_W = 8,
  parameter int unsigned CHAN_W = 3
) (
  input  logic              cs_ni,
  input  logic              rd_ni,
  input  bus_mode_e         mode_i,
  input  logic              hben_i,
  input  logic [DATA_W-1:0] result_i,
  input  logic [CHAN_W-1:0] tag_i,
  output logic [DATA_W-1:0] db_o,
  output logic              oe_o
);
  localparam int unsigned HI_W = DATA_W - BYTE_W;
  localparam int unsigned PAD  = BYTE_W - HI_W - CHAN_W;

  logic [BYTE_W-1:0] hi_byte;
  assign hi_byte = {{PAD{1'b0}}, tag_i, result_i[DATA_W-1:BYTE_W]};

  always_comb begin
    oe_o = ~cs_ni & ~rd_ni;
    db_o = '0;
    if (oe_o) begin
      if (mode_i == BUS_WORD) db_o = result_i;
      else if (hben_i)        db_o = DATA_W'(hi_byte);
      else                    db_o = DATA_W'(result_i[BYTE_W-1:0]);
    end
  end
endmodule

// File: rtl/adc_pbus_frontend.sv
`timescale 1ns/1ps
module adc_pbus_frontend
  import adc_pbus_pkg::*;
#(
  parameter int unsigned DATA_W      = 12,
  parameter int unsigned BYTE_W      = 8,
  parameter int unsigned CHAN_W      = 3,
  parameter int unsigned CONV_CYCLES = 13
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              conv_start_ni,
  input  logic [DATA_W-1:0] sample_i,
  input  logic              word_mode_i,
  input  logic              cs_ni,
  input  logic              rd_ni,
  input  logic              wr_ni,
  input  logic [DATA_W-1:0] db_i,
  output logic [DATA_W-1:0] db_o,
  output logic              db_oe_o,
  output logic              busy_o
);
  bus_mode_e         mode;
  logic [CHAN_W-1:0] chan, tag;
  logic [DATA_W-1:0] result;

  adc_bus_ctrl #(.DATA_W(DATA_W), .BYTE_W(BYTE_W), .CHAN_W(CHAN_W)) u_ctrl (
    .clk_i(clk_i), .rst_ni(rst_ni), .cs_ni(cs_ni), .wr_ni(wr_ni),
    .mode_i(word_mode_i), .db_i(db_i), .mode_o(mode), .chan_o(chan));

  adc_conv_seq #(.DATA_W(DATA_W), .CHAN_W(CHAN_W), .CONV_CYCLES(CONV_CYCLES)) u_seq (
    .clk_i(clk_i), .rst_ni(rst_ni), .start_ni(conv_start_ni), .chan_i(chan),
    .sample_i(sample_i), .busy_o(busy_o), .result_o(result), .tag_o(tag));

  adc_read_mux #(.DATA_W(DATA_W), .BYTE_W(BYTE_W), .CHAN_W(CHAN_W)) u_mux (
    .cs_ni(cs_ni), .rd_ni(rd_ni), .mode_i(mode), .hben_i(db_i[BYTE_W]),
    .result_i(result), .tag_i(tag), .db_o(db_o), .oe_o(db_oe_o));

  a_r3_idle_bus: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cs_ni || rd_ni) |-> (!db_oe_o && db_o == '0));
  a_r6_high_pad: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (db_oe_o && mode == BUS_BYTE && db_i[BYTE_W]) |-> (db_o[DATA_W-1:BYTE_W-1] == '0));
  a_r5_low_pad: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (db_oe_o && mode == BUS_BYTE) |-> (db_o[DATA_W-1:BYTE_W] == '0));
endmodule

// File: tb/tb_adc_pbus_frontend.sv
`timescale 1ns/1ps
module tb_adc_pbus_frontend;
  logic        clk = 1'b0, rst_ni = 1'b0;
  logic        conv_start_ni = 1'b1, word_mode_i = 1'b1;
  logic        cs_ni = 1'b1, rd_ni = 1'b1, wr_ni = 1'b1;
  logic [11:0] sample_i = '0, db_i = '0;
  logic [11:0] db_o;
  logic        db_oe_o, busy_o;
  int          errors = 0, checks = 0, busy_cyc = 0;
  bit          finished = 0;

  adc_pbus_frontend dut (
    .clk_i(clk), .rst_ni(rst_ni), .conv_start_ni(conv_start_ni), .sample_i(sample_i),
    .word_mode_i(word_mode_i), .cs_ni(cs_ni), .rd_ni(rd_ni), .wr_ni(wr_ni),
    .db_i(db_i), .db_o(db_o), .db_oe_o(db_oe_o), .busy_o(busy_o));

  always #2.5 clk = ~clk;
  always @(negedge clk) if (busy_o) busy_cyc++;

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic do_write(input bit m, input logic [11:0] d);
    @(negedge clk); word_mode_i = m; cs_ni = 1'b1;
    @(negedge clk); cs_ni = 1'b0; wr_ni = 1'b0; db_i = d;
    @(negedge clk); wr_ni = 1'b1; cs_ni = 1'b1; db_i = '0;
  endtask

  task automatic do_read(input bit m, input bit hb, output int val);
    @(negedge clk); word_mode_i = m; cs_ni = 1'b1;
    @(negedge clk); cs_ni = 1'b0; rd_ni = 1'b0; db_i = {3'b0, hb, 8'h00};
    #1 val = db_o;
    chk("R3 oe during read", db_oe_o, 1);
    rd_ni = 1'b1; cs_ni = 1'b1; db_i = '0;
    #1 chk("R3 oe after read", db_oe_o, 0);
  endtask

  task automatic start_conv(input logic [11:0] s);
    @(negedge clk); sample_i = s; conv_start_ni = 1'b0; busy_cyc = 0;
    @(posedge clk);
  endtask

  task automatic wait_done();
    for (int g = 0; g < 100; g++) begin
      @(negedge clk);
      if (!busy_o) break;
    end
    conv_start_ni = 1'b1;
  endtask

  task automatic full_check(input logic [11:0] s, input int ch);
    int v;
    start_conv(s);
    @(negedge clk); chk("R1 busy after start", busy_o, 1);
    wait_done();
    chk("R2 busy length", busy_cyc, 13);
    do_read(1'b1, 1'b0, v); chk("R4 word read", v, s);
    do_read(1'b0, 1'b0, v); chk("R5 low byte", v, s & 12'h0FF);
    do_read(1'b0, 1'b1, v); chk("R6 high byte", v, ((ch & 7) << 4) | (s >> 8));
  endtask

  initial begin
    #(200000 * 5);
    if (!finished) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=hung expected=done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    int v;
    repeat (3) @(posedge clk);
    @(negedge clk); rst_ni = 1'b1;
    chk("R2 reset busy", busy_o, 0);
    chk("R3 reset oe", db_oe_o, 0);
    chk("R3 reset data", db_o, 0);
    do_read(1'b1, 1'b0, v); chk("R4 reset result", v, 0);

    // sweep all channels with spread values, plus corners
    for (int ch = 0; ch < 8; ch++) begin
      do_write(1'b1, 12'(ch << 8));
      for (int k = 0; k < 4; k++)
        full_check(12'((ch * 517 + k * 1231 + 7) & 12'hFFF), ch);
    end
    full_check(12'h000, 7);
    full_check(12'hFFF, 7);

    // R3 partial strobes
    @(negedge clk); cs_ni = 1'b0; #1 chk("R3 cs only", db_oe_o, 0); chk("R3 cs only data", db_o, 0);
    cs_ni = 1'b1; rd_ni = 1'b0; #1 chk("R3 rd only", db_oe_o, 0);
    rd_ni = 1'b1;

    // R7 byte writes
    do_write(1'b0, 12'h105);
    full_check(12'h3C1, 5);
    do_write(1'b0, 12'h003);
    full_check(12'h24E, 5);
    // R8 reserved bits
    do_write(1'b0, 12'h112);
    full_check(12'h911, 5);
    do_write(1'b0, 12'h10A);
    full_check(12'h822, 5);
    do_write(1'b1, 12'h900);
    full_check(12'h477, 5);
    do_write(1'b1, 12'h200);
    full_check(12'hA5C, 2);

    // R9 mode change while selected
    do_read(1'b0, 1'b0, v);
    @(negedge clk); cs_ni = 1'b0;
    @(negedge clk); word_mode_i = 1'b1;
    @(negedge clk); rd_ni = 1'b0;
    #1 chk("R9 mode held while selected", db_o, 12'h05C);
    rd_ni = 1'b1; cs_ni = 1'b1;
    @(negedge clk); cs_ni = 1'b0; rd_ni = 1'b0;
    #1 chk("R9 mode taken when deselected", db_o, 12'hA5C);
    rd_ni = 1'b1; cs_ni = 1'b1;

    // R10 start edge during conversion
    start_conv(12'h6B3);
    repeat (3) @(negedge clk);
    conv_start_ni = 1'b1;
    @(negedge clk); conv_start_ni = 1'b0;
    wait_done();
    chk("R10 busy not extended", busy_cyc, 13);
    do_read(1'b1, 1'b0, v); chk("R10 result", v, 12'h6B3);

    // R11 channel write during conversion
    start_conv(12'h1F0);
    do_write(1'b1, 12'h600);
    chk("R11 still busy", busy_o, 1);
    wait_done();
    do_read(1'b0, 1'b1, v); chk("R11 tag from start", v, (2 << 4) | 1);
    full_check(12'h0E4, 6);

    finished = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule